// File: doc/BRIEF.md
# Mirrored Two-Source Register File

This block is the operand store of a small processor core. Every cycle it can deliver two source registers and accept one destination write, so an instruction of the form `dst <= src1 op src2` finishes its register access in a single clock. No mux shares one memory port between source and destination addresses across two cycles.

The storage is held twice. Each copy is a memory with one write port and one read port. The write port of both copies takes the same enable, address and data in the same cycle, so the two copies always hold the same values. Copy 0 serves source port A and copy 1 serves source port B. Reads are registered and return data one clock after the address is presented. When a read and a write name the same register in the same cycle, the read returns the value being written (write-first).

Top module: `reg_mirror_file`

## Requirements
- R1: While `rst` is high at a rising edge, both read data outputs are zero after that edge.
- R2: A write with `wr_en` high stores `wr_data` at `wr_addr`, and later reads of that address on either port return it.
- R3: With `wr_en` low, no register changes, whatever `wr_addr` and `wr_data` carry.
- R4: Read data shows the register named by the read address at the previous rising edge, with exactly one cycle of latency.
- R5: Ports A and B read different addresses independently in the same cycle.
- R6: If `wr_en` is high and `wr_addr` equals `rd_a_addr` in the same cycle, `rd_a_data` returns the new `wr_data` one cycle later.
- R7: If `wr_en` is high and `wr_addr` equals `rd_b_addr` in the same cycle, `rd_b_data` returns the new `wr_data` one cycle later.
- R8: Reading the same address on both ports in the same cycle gives identical data, for every address and after any write sequence, because both copies are always written together.
- R9: There are 16 registers with 4-bit addresses 0 to 15, each holding its own value. The default data width is 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the read outputs |
| wr_en | input | 1 | Destination write enable, applied to both copies |
| wr_addr | input | AW (4) | Destination register address |
| wr_data | input | DW (16) | Destination write data |
| rd_a_addr | input | AW (4) | Source A register address |
| rd_a_data | output | DW (16) | Source A data, one cycle after the address |
| rd_b_addr | input | AW (4) | Source B register address |
| rd_b_data | output | DW (16) | Source B data, one cycle after the address |

## Verification
A destination write and a source read can name the same register in one cycle, on port A, port B or both. The bench provokes this on purpose in directed cases and often in random traffic that draws from a narrow address range. The scoreboard expects the value being written, not the stale one. After the random phase, every address is read on both ports at once, which proves the copies never drifted apart.

// File: rtl/rf_pkg.sv
package rf_pkg;
    // number of mirrored storage copies, one per source operand port
    localparam int NCOPY = 2;

    typedef enum logic [0:0] {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } src_sel_e;
endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
    parameter int DW   = 16,
    parameter int NREG = 16,
    parameter int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= mem[raddr];
    end

    // R4: with no writes for two cycles and a steady address, the read output holds
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!we && !$past(we) && raddr == $past(raddr) && !$past(rst)) |=> $stable(rdata));
endmodule

// File: rtl/rf_fwd.sv
module rf_fwd #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    input  logic [DW-1:0] bank_q,
    output logic [DW-1:0] dout
);
    logic          hit_q;
    logic [DW-1:0] byp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= 1'b0;
            byp_q <= '0;
        end else begin
            hit_q <= we && (waddr == raddr);
            byp_q <= wdata;
        end
    end

    always_comb dout = hit_q ? byp_q : bank_q;

    // R6 R7: a same-cycle write to the read address is returned next cycle
    wr_first_chk: assert property (@(posedge clk) disable iff (rst)
        (we && waddr == raddr) |=> (dout == $past(wdata)));

    // R1: reset leaves the read output at zero
    rst_zero_chk: assert property (@(posedge clk)
        $past(rst) |-> (dout == '0));
endmodule

// File: rtl/reg_mirror_file.sv
module reg_mirror_file
    import rf_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_a_addr,
    output logic [DW-1:0] rd_a_data,
    input  logic [AW-1:0] rd_b_addr,
    output logic [DW-1:0] rd_b_data
);
    logic [AW-1:0] raddr_v [NCOPY];
    logic [DW-1:0] bankq_v [NCOPY];
    logic [DW-1:0] dout_v  [NCOPY];

    always_comb begin
        raddr_v[SRC_A] = rd_a_addr;
        raddr_v[SRC_B] = rd_b_addr;
    end

    // one write port fans out to every copy with a single shared enable
    for (genvar g = 0; g < NCOPY; g++) begin : g_copy
        rf_bank #(.DW(DW), .NREG(NREG), .AW(AW)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (wr_en),
            .waddr (wr_addr),
            .wdata (wr_data),
            .raddr (raddr_v[g]),
            .rdata (bankq_v[g])
        );

        rf_fwd #(.DW(DW), .AW(AW)) u_fwd (
            .clk    (clk),
            .rst    (rst),
            .we     (wr_en),
            .waddr  (wr_addr),
            .wdata  (wr_data),
            .raddr  (raddr_v[g]),
            .bank_q (bankq_v[g]),
            .dout   (dout_v[g])
        );
    end

    assign rd_a_data = dout_v[SRC_A];
    assign rd_b_data = dout_v[SRC_B];

    // R8
    mirror_match_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_a_addr == rd_b_addr) |=> (rd_a_data == rd_b_data));

    // R3
    no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !$past(wr_en) && !$past(rst) && rd_a_addr == $past(rd_a_addr))
        |=> $stable(rd_a_data));
endmodule

// File: tb/reg_mirror_file_test.sv
module reg_mirror_file_test;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam int NR = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_a_addr = '0;
    logic [AW-1:0] rd_b_addr = '0;
    logic [DW-1:0] rd_a_data;
    logic [DW-1:0] rd_b_data;

    always #2.5 clk = ~clk;

    reg_mirror_file #(.DW(DW), .NREG(NR)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
    );

    typedef struct {
        logic [DW-1:0] exp_a;
        logic [DW-1:0] exp_b;
        string         tag;
    } item_t;

    item_t         sbq[$];
    logic [DW-1:0] model [NR];
    int            n_vec  = 0;
    int            n_fail = 0;
    bit            done   = 1'b0;

    // monitor: outputs settle after the edge, compare 1 ns later
    always @(posedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            n_vec++;
            if (rd_a_data !== it.exp_a) begin
                n_fail++;
                $display("FAIL %s port A: got %h expected %h", it.tag, rd_a_data, it.exp_a);
            end
            if (rd_b_data !== it.exp_b) begin
                n_fail++;
                $display("FAIL %s port B: got %h expected %h", it.tag, rd_b_data, it.exp_b);
            end
        end
    end

    // driver: applies one cycle at the falling edge and queues its expectation
    task automatic step(input logic r, input logic we, input logic [AW-1:0] wa,
                        input logic [DW-1:0] wd, input logic [AW-1:0] ra,
                        input logic [AW-1:0] rb, input string tag);
        item_t it;
        @(negedge clk);
        rst = r; wr_en = we; wr_addr = wa; wr_data = wd;
        rd_a_addr = ra; rd_b_addr = rb;
        if (r) begin
            it.exp_a = '0;
            it.exp_b = '0;
        end else begin
            it.exp_a = (we && wa == ra) ? wd : model[ra];
            it.exp_b = (we && wa == rb) ? wd : model[rb];
        end
        it.tag = tag;
        sbq.push_back(it);
        if (we) model[wa] = wd;
    endtask

    initial begin
        // R1: reset cycles
        step(1, 0, 0, 0, 0, 0, "R1");
        step(1, 0, 0, 0, 0, 0, "R1");
        // R9 R2: fill all 16 registers with distinct values
        for (int i = 0; i < NR; i++)
            step(0, 1, AW'(i), DW'(16'hA000 + i * 16'h0111), AW'((i + 1) % NR), AW'((i + 2) % NR), "R2");
        // R9 R4 R5: read every register, A and B on different addresses
        for (int i = 0; i < NR; i++)
            step(0, 0, 0, 0, AW'(i), AW'(NR - 1 - i), "R9_R4_R5");
        // R3: writes with enable low must not land
        step(0, 0, 4'd5, 16'hDEAD, 4'd5, 4'd5, "R3");
        step(0, 0, 4'd9, 16'hBEEF, 4'd5, 4'd9, "R3");
        step(0, 0, 0, 0, 4'd9, 4'd5, "R3");
        // R6: same-cycle write and read on port A
        step(0, 1, 4'd3, 16'h1234, 4'd3, 4'd4, "R6");
        // R7: same-cycle write and read on port B
        step(0, 1, 4'd7, 16'h5678, 4'd2, 4'd7, "R7");
        // R6 R7: both ports hit the target
        step(0, 1, 4'd15, 16'hCAFE, 4'd15, 4'd15, "R6_R7");
        step(0, 0, 0, 0, 4'd3, 4'd7, "R2");
        // random traffic with a narrow address range to force collisions
        for (int k = 0; k < 400; k++) begin
            logic [AW-1:0] m;
            m = (k % 2 == 0) ? 4'd3 : 4'd15;
            step(0, 1'($urandom_range(0, 1)), AW'($urandom) & m, DW'($urandom),
                 AW'($urandom) & m, AW'($urandom) & m, "R2_R6_R7");
        end
        // R8: both ports read the same address, all addresses
        for (int i = 0; i < NR; i++)
            step(0, 0, 0, 0, AW'(i), AW'(i), "R8");
        // R1: reset again after traffic
        step(1, 1, 4'd1, 16'h7777, 4'd1, 4'd1, "R1");
        step(0, 0, 0, 0, 4'd1, 4'd2, "R1_R3");
        step(0, 0, 0, 0, 4'd0, 4'd0, "R4");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule